// File: doc/BRIEF.md
# Session Receive Buffer with Announce-and-Fetch Delivery

This block sits between a TCP engine and the application that consumes its payload. Bytes arriving for a session are written into a small circular buffer owned by that session. When a segment ends, the block queues a notification naming the session, the number of bytes it kept, and the remote endpoint (address and port). A session teardown queues a notification of its own, with its closed flag set. Both kinds leave the block in the order their events arrived.

Payload never leaves the block on its own initiative. The application answers a notification with a fetch request that names a session and a byte count. The block replies with one metadata word carrying the session ID. It then sends the bytes as a stream of beats, each with per-byte keep bits and a last marker. A request for more bytes than are held is cut down to what is held. Bytes that arrive when a session's buffer is already full are discarded and counted.

The input is a simplified, already in-order byte stream. Each beat carries a session ID, one data byte and an end-of-segment flag. Session IDs presented to the block must be below the session count.

Top module: `rx_fetch_buffer`

## Requirements
- R1: After reset, all three valid outputs (`ntf_valid`, `meta_valid`, `pl_valid`) are low, `drop_count` is zero, and both `seg_ready` and `rdq_ready` are high.
- R2: The end-of-segment byte is accepted on a clock edge, and from that edge a notification is queued. It carries the segment's session, a length equal to the bytes of that segment actually stored, the address and port present with the end-of-segment byte, and closed = 0.
- R3: Each session holds at most BUF_BYTES bytes. A byte that arrives when its session is full is discarded, `drop_count` rises by exactly one for it, and the byte is not counted in the notification length.
- R4: An accepted fetch request first produces one `meta_valid` word whose `meta_sess` equals the requested session. No payload beat is presented before that word has been taken.
- R5: The number of payload bytes returned is the smaller of the requested length and the bytes stored for that session when the request is accepted.
- R6: Each beat carries up to BEAT_BYTES bytes. Byte k of the beat sits in bits 8k+7..8k. `pl_keep` is a run of ones starting at bit 0, one bit per valid byte. `pl_last` is set on the final beat only.
- R7: A fetch that resolves to zero bytes (zero request, or an empty session) returns the metadata word and then a single beat with `pl_keep` = 0 and `pl_last` = 1.
- R8: A close event queues a notification with closed = 1 and length 0. It carries the address and port last recorded for that session, and it comes out after every notification queued before it.
- R9: Notifications leave in the order their events were accepted. While `ntf_valid` is high and `ntf_ready` is low, the notification fields hold still.
- R10: Bytes of a session are returned in arrival order. This holds across partial fetches and across buffer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | Input byte valid |
| seg_ready | output | 1 | Input byte can be taken |
| seg_sess | input | 16 | Session of the input byte |
| seg_byte | input | 8 | Payload byte |
| seg_last | input | 1 | Final byte of the segment |
| seg_ip | input | 32 | Remote address, sampled with the final byte |
| seg_port | input | 16 | Remote port, sampled with the final byte |
| cls_valid | input | 1 | Close event valid |
| cls_ready | output | 1 | Close event can be taken |
| cls_sess | input | 16 | Session being closed |
| ntf_valid | output | 1 | Notification valid |
| ntf_ready | input | 1 | Notification taken |
| ntf_sess | output | 16 | Notification session |
| ntf_len | output | 16 | Bytes announced |
| ntf_ip | output | 32 | Remote address |
| ntf_port | output | 16 | Remote port |
| ntf_closed | output | 1 | Session closed flag |
| rdq_valid | input | 1 | Fetch request valid |
| rdq_ready | output | 1 | Fetch request can be taken |
| rdq_sess | input | 16 | Session to fetch from |
| rdq_len | input | 16 | Bytes requested |
| meta_valid | output | 1 | Metadata word valid |
| meta_ready | input | 1 | Metadata word taken |
| meta_sess | output | 16 | Session of the fetch reply |
| pl_valid | output | 1 | Payload beat valid |
| pl_ready | input | 1 | Payload beat taken |
| pl_data | output | 32 | Payload bytes, byte k in bits 8k+7..8k |
| pl_keep | output | 4 | Per-byte valid mask |
| pl_last | output | 1 | Final beat of the reply |
| drop_count | output | 16 | Count of discarded input bytes |

## Verification
A read or write pointer that is off by one shows up at the ports as a wrong byte value or a shifted keep mask. This happens on the very next fetch from that session. A fill count that is wrong becomes visible twice. The next notification after the session fills carries the wrong length, and `drop_count` steps at the wrong byte. A clamped fetch then returns the wrong number of bytes. A notification queue that loses its ordering makes a close overtake data, which is seen at the first close that follows data. A read engine that skips its metadata state shows a payload beat before any metadata word.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int SID_W  = 16;
    localparam int LEN_W  = 16;
    localparam int IP_W   = 32;
    localparam int PORT_W = 16;

    typedef struct packed {
        logic [SID_W-1:0]  sess;
        logic [LEN_W-1:0]  len;
        logic [IP_W-1:0]   ip;
        logic [PORT_W-1:0] port;
        logic              closed;
    } ntf_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_META,
        RD_DATA
    } rd_state_e;

    function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int NUM_SESS   = 4,
    parameter int BUF_BYTES  = 16,
    parameter int BEAT_BYTES = 4,
    localparam int IW = $clog2(NUM_SESS),
    localparam int AW = $clog2(BUF_BYTES),
    localparam int CW = $clog2(BEAT_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic [7:0]              wr_byte,
    output logic                    wr_ok,
    input  logic [IW-1:0]           rd_idx,
    output logic [8*BEAT_BYTES-1:0] rd_bytes,
    output logic [AW:0]             rd_fill,
    input  logic                    pop_en,
    input  logic [CW-1:0]           pop_cnt
);
    localparam logic [AW:0] CAP = (AW+1)'(BUF_BYTES);

    logic [7:0] mem [NUM_SESS][BUF_BYTES];
    logic [AW:0] wp [NUM_SESS];
    logic [AW:0] rp [NUM_SESS];
    logic [AW:0] wfill;

    assign wfill   = wp[wr_idx] - rp[wr_idx];
    assign wr_ok   = wr_en && (wfill < CAP);
    assign rd_fill = wp[rd_idx] - rp[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_idx][wp[wr_idx][AW-1:0]] <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SESS; i++) begin
                wp[i] <= '0;
                rp[i] <= '0;
            end
        end else begin
            if (wr_ok)  wp[wr_idx] <= wp[wr_idx] + 1'b1;
            if (pop_en) rp[rd_idx] <= rp[rd_idx] + (AW+1)'(pop_cnt);
        end
    end

    for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
        logic [AW-1:0] addr;
        assign addr = rp[rd_idx][AW-1:0] + AW'(k);
        assign rd_bytes[8*k +: 8] = mem[rd_idx][addr];
    end

    for (genvar s = 0; s < NUM_SESS; s++) begin : g_chk
        assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
            (wp[s] - rp[s]) <= CAP);
    end
endmodule

// File: rtl/rxb_ntf_fifo.sv
module rxb_ntf_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  ntf_t din,
    output logic full,
    output logic valid,
    input  logic ready,
    output ntf_t dout
);
    ntf_t q [DEPTH];
    logic [PW:0] wp, rp;

    assign full  = (wp - rp) == (PW+1)'(DEPTH);
    assign valid = (wp != rp);
    assign dout  = q[rp[PW-1:0]];

    always_ff @(posedge clk) begin
        if (push) q[wp[PW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push)          wp <= wp + 1'b1;
            if (valid && ready) rp <= rp + 1'b1;
        end
    end

    assert_ntf_hold_R9: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(dout));
endmodule

// File: rtl/rxb_rd_engine.sv
module rxb_rd_engine
    import rxb_pkg::*;
#(
    parameter int NUM_SESS   = 4,
    parameter int BUF_BYTES  = 16,
    parameter int BEAT_BYTES = 4,
    localparam int IW = $clog2(NUM_SESS),
    localparam int AW = $clog2(BUF_BYTES),
    localparam int CW = $clog2(BEAT_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rq_valid,
    output logic                  rq_ready,
    input  logic [SID_W-1:0]      rq_sess,
    input  logic [LEN_W-1:0]      rq_len,
    input  logic [AW:0]           fill,
    output logic [IW-1:0]         idx,
    output logic                  meta_valid,
    input  logic                  meta_ready,
    output logic [SID_W-1:0]      meta_sess,
    output logic                  pl_valid,
    input  logic                  pl_ready,
    output logic [BEAT_BYTES-1:0] pl_keep,
    output logic                  pl_last,
    output logic                  pop_en,
    output logic [CW-1:0]         pop_cnt
);
    localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);

    rd_state_e        state;
    logic [SID_W-1:0] cur;
    logic [LEN_W-1:0] rem;

    assign rq_ready   = (state == RD_IDLE);
    assign idx        = (state == RD_IDLE) ? rq_sess[IW-1:0] : cur[IW-1:0];
    assign meta_valid = (state == RD_META);
    assign meta_sess  = cur;
    assign pl_valid   = (state == RD_DATA);
    assign pl_last    = (rem <= BEAT_L);
    assign pop_cnt    = pl_last ? CW'(rem) : CW'(BEAT_BYTES);
    assign pop_en     = pl_valid && pl_ready;

    for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_keep
        assign pl_keep[k] = LEN_W'(k) < rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
            cur   <= '0;
            rem   <= '0;
        end else begin
            case (state)
                RD_IDLE: if (rq_valid) begin
                    cur   <= rq_sess;
                    rem   <= min_len(rq_len, LEN_W'(fill));
                    state <= RD_META;
                end
                RD_META: if (meta_ready) state <= RD_DATA;
                RD_DATA: if (pl_ready) begin
                    rem <= rem - LEN_W'(pop_cnt);
                    if (pl_last) state <= RD_IDLE;
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assert_meta_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pl_valid) |-> $past(meta_valid && meta_ready));
    assert_keep_contig_R6: assert property (@(posedge clk) disable iff (rst)
        pl_valid |-> ((pl_keep & (pl_keep + BEAT_BYTES'(1))) == '0));
    assert_pl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        pl_valid && !pl_ready |=> pl_valid && $stable(pl_keep) && $stable(pl_last));
endmodule

// File: rtl/rx_fetch_buffer.sv
module rx_fetch_buffer
    import rxb_pkg::*;
#(
    parameter int NUM_SESS   = 4,
    parameter int BUF_BYTES  = 16,
    parameter int BEAT_BYTES = 4,
    parameter int NTF_DEPTH  = 4,
    parameter int DROP_W     = 16,
    localparam int IW = $clog2(NUM_SESS),
    localparam int AW = $clog2(BUF_BYTES),
    localparam int CW = $clog2(BEAT_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    seg_valid,
    output logic                    seg_ready,
    input  logic [SID_W-1:0]        seg_sess,
    input  logic [7:0]              seg_byte,
    input  logic                    seg_last,
    input  logic [IP_W-1:0]         seg_ip,
    input  logic [PORT_W-1:0]       seg_port,
    input  logic                    cls_valid,
    output logic                    cls_ready,
    input  logic [SID_W-1:0]        cls_sess,
    output logic                    ntf_valid,
    input  logic                    ntf_ready,
    output logic [SID_W-1:0]        ntf_sess,
    output logic [LEN_W-1:0]        ntf_len,
    output logic [IP_W-1:0]         ntf_ip,
    output logic [PORT_W-1:0]       ntf_port,
    output logic                    ntf_closed,
    input  logic                    rdq_valid,
    output logic                    rdq_ready,
    input  logic [SID_W-1:0]        rdq_sess,
    input  logic [LEN_W-1:0]        rdq_len,
    output logic                    meta_valid,
    input  logic                    meta_ready,
    output logic [SID_W-1:0]        meta_sess,
    output logic                    pl_valid,
    input  logic                    pl_ready,
    output logic [8*BEAT_BYTES-1:0] pl_data,
    output logic [BEAT_BYTES-1:0]   pl_keep,
    output logic                    pl_last,
    output logic [DROP_W-1:0]       drop_count
);
    logic              q_full, wr_en, wr_ok, push_seg, push_cls, pop_en;
    logic [IW-1:0]     rd_idx;
    logic [AW:0]       rd_fill;
    logic [CW-1:0]     pop_cnt;
    logic [LEN_W-1:0]  seg_cnt;
    logic [IP_W-1:0]   ep_ip   [NUM_SESS];
    logic [PORT_W-1:0] ep_port [NUM_SESS];
    ntf_t              q_din, q_dout;

    assign seg_ready = !q_full;
    assign cls_ready = !q_full && !(seg_valid && seg_last);
    assign wr_en     = seg_valid && seg_ready;
    assign push_seg  = wr_en && seg_last;
    assign push_cls  = cls_valid && cls_ready;

    always_comb begin
        if (push_seg) begin
            q_din = '{sess: seg_sess, len: seg_cnt + LEN_W'(wr_ok),
                      ip: seg_ip, port: seg_port, closed: 1'b0};
        end else begin
            q_din = '{sess: cls_sess, len: '0, ip: ep_ip[cls_sess[IW-1:0]],
                      port: ep_port[cls_sess[IW-1:0]], closed: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_cnt    <= '0;
            drop_count <= '0;
            for (int i = 0; i < NUM_SESS; i++) begin
                ep_ip[i]   <= '0;
                ep_port[i] <= '0;
            end
        end else begin
            if (wr_en) seg_cnt <= seg_last ? '0 : seg_cnt + LEN_W'(wr_ok);
            if (wr_en && !wr_ok) drop_count <= drop_count + 1'b1;
            if (push_seg) begin
                ep_ip[seg_sess[IW-1:0]]   <= seg_ip;
                ep_port[seg_sess[IW-1:0]] <= seg_port;
            end
        end
    end

    rxb_store #(.NUM_SESS(NUM_SESS), .BUF_BYTES(BUF_BYTES), .BEAT_BYTES(BEAT_BYTES)) i_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(seg_sess[IW-1:0]), .wr_byte(seg_byte),
        .wr_ok(wr_ok), .rd_idx(rd_idx), .rd_bytes(pl_data), .rd_fill(rd_fill),
        .pop_en(pop_en), .pop_cnt(pop_cnt)
    );

    rxb_ntf_fifo #(.DEPTH(NTF_DEPTH)) i_ntf (
        .clk(clk), .rst(rst), .push(push_seg || push_cls), .din(q_din), .full(q_full),
        .valid(ntf_valid), .ready(ntf_ready), .dout(q_dout)
    );

    assign ntf_sess   = q_dout.sess;
    assign ntf_len    = q_dout.len;
    assign ntf_ip     = q_dout.ip;
    assign ntf_port   = q_dout.port;
    assign ntf_closed = q_dout.closed;

    rxb_rd_engine #(.NUM_SESS(NUM_SESS), .BUF_BYTES(BUF_BYTES), .BEAT_BYTES(BEAT_BYTES)) i_rd (
        .clk(clk), .rst(rst), .rq_valid(rdq_valid), .rq_ready(rdq_ready), .rq_sess(rdq_sess),
        .rq_len(rdq_len), .fill(rd_fill), .idx(rd_idx), .meta_valid(meta_valid),
        .meta_ready(meta_ready), .meta_sess(meta_sess), .pl_valid(pl_valid),
        .pl_ready(pl_ready), .pl_keep(pl_keep), .pl_last(pl_last), .pop_en(pop_en),
        .pop_cnt(pop_cnt)
    );

    assert_drop_step_R3: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(push_seg && push_cls));
endmodule

// File: tb/test_rx_fetch_buffer.sv
`timescale 1ns/1ps
module test_rx_fetch_buffer;
    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic seg_valid = 0, seg_ready, seg_last = 0;
    logic [15:0] seg_sess = 0; logic [7:0] seg_byte = 0;
    logic [31:0] seg_ip = 0; logic [15:0] seg_port = 0;
    logic cls_valid = 0, cls_ready; logic [15:0] cls_sess = 0;
    logic ntf_valid, ntf_ready = 0, ntf_closed;
    logic [15:0] ntf_sess, ntf_len, ntf_port; logic [31:0] ntf_ip;
    logic rdq_valid = 0, rdq_ready; logic [15:0] rdq_sess = 0, rdq_len = 0;
    logic meta_valid, meta_ready = 0; logic [15:0] meta_sess;
    logic pl_valid, pl_ready = 0, pl_last; logic [31:0] pl_data; logic [3:0] pl_keep;
    logic [15:0] drop_count;

    rx_fetch_buffer i_rx_fetch_buffer (.*);

    int n_chk = 0, n_bad = 0, exp_drop = 0;
    logic [7:0] mq [4][$];

    // sess, byte count, first byte value, fetch length
    localparam logic [39:0] VEC [6] = '{
        {8'd0, 8'd5,  8'h10, 16'd5},
        {8'd1, 8'd8,  8'h20, 16'd3},
        {8'd1, 8'd4,  8'h30, 16'd20},
        {8'd2, 8'd1,  8'h40, 16'd1},
        {8'd3, 8'd12, 8'h50, 16'd8},
        {8'd3, 8'd4,  8'h60, 16'd8}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_seg(input int s, input int n, input int start,
                            input logic [31:0] ip, input logic [15:0] port, output int kept);
        kept = 0;
        for (int i = 0; i < n; i++) begin
            seg_valid = 1; seg_sess = 16'(s); seg_byte = 8'(start + i);
            seg_last = (i == n - 1); seg_ip = ip; seg_port = port;
            while (!seg_ready) @(negedge clk);
            @(negedge clk);
            if (mq[s].size() < 16) begin mq[s].push_back(8'(start + i)); kept++; end
            else exp_drop++;
        end
        seg_valid = 0; seg_last = 0;
    endtask

    task automatic expect_ntf(input int s, input int len, input logic [31:0] ip,
                              input logic [15:0] port, input bit closed, input string tag);
        while (!ntf_valid) @(negedge clk);
        check(ntf_sess == 16'(s) && ntf_len == 16'(len) && ntf_ip == ip &&
              ntf_port == port && ntf_closed == closed, tag,
              {ntf_sess, ntf_len, 15'(ntf_port), ntf_closed},
              {16'(s), 16'(len), 15'(port), closed});
        ntf_ready = 1; @(negedge clk); ntf_ready = 0;
    endtask

    task automatic do_read(input int s, input int len, input string tag);
        int rem, n, beats;
        rem = (len < mq[s].size()) ? len : mq[s].size();
        rdq_valid = 1; rdq_sess = 16'(s); rdq_len = 16'(len);
        while (!rdq_ready) @(negedge clk);
        @(negedge clk); rdq_valid = 0;
        check(!pl_valid, {tag, " R4 no payload before meta"}, pl_valid, 0);
        while (!meta_valid) @(negedge clk);
        check(meta_sess == 16'(s), {tag, " R4 meta session"}, meta_sess, s);
        meta_ready = 1; @(negedge clk); meta_ready = 0;
        beats = 0;
        forever begin
            while (!pl_valid) @(negedge clk);
            n = (rem > 4) ? 4 : rem;
            check(pl_keep == 4'((1 << n) - 1), {tag, " R5 R6 keep"}, pl_keep, (1 << n) - 1);
            check(pl_last == (rem <= 4), {tag, " R6 last"}, pl_last, rem <= 4);
            for (int k = 0; k < n; k++) begin
                logic [7:0] e;
                e = mq[s].pop_front();
                check(pl_data[8*k +: 8] == e, {tag, " R10 byte order"}, pl_data[8*k +: 8], e);
            end
            rem -= n; beats++;
            pl_ready = 1; @(negedge clk); pl_ready = 0;
            if (rem <= 0 && n < 4 || rem <= 0 && beats > 0 && !pl_valid) break;
            if (beats > 8) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int kept;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!ntf_valid && !meta_valid && !pl_valid, "R1 valids low", {ntf_valid, meta_valid, pl_valid}, 0);
        check(drop_count == 0, "R1 drop count", drop_count, 0);
        check(seg_ready && rdq_ready, "R1 ready", {seg_ready, rdq_ready}, 3);

        // table walk: R2, R5, R6, R10
        foreach (VEC[i]) begin
            int s, n, st, rl;
            s = VEC[i][39:32]; n = VEC[i][31:24]; st = VEC[i][23:16]; rl = VEC[i][15:0];
            send_seg(s, n, st, 32'h0A00_0000 + s, 16'(1000 + i), kept);
            expect_ntf(s, kept, 32'h0A00_0000 + s, 16'(1000 + i), 0, "R2 data notification");
            do_read(s, rl, "R5 table fetch");
        end

        // R3 overflow on an empty session, wraps its pointers
        send_seg(0, 20, 8'h80, 32'hC0A8_0001, 16'd7, kept);
        expect_ntf(0, 16, 32'hC0A8_0001, 16'd7, 0, "R3 notification length after drops");
        check(drop_count == 16'(exp_drop), "R3 drop count", drop_count, exp_drop);
        do_read(0, 16, "R3 R10 full buffer fetch");

        // R7 zero-length fetch on empty session, and zero request on stored data
        do_read(0, 8, "R7 empty session");
        send_seg(2, 3, 8'hA0, 32'h0B00_0002, 16'd55, kept);
        do_read(2, 0, "R7 zero request");
        check(mq[2].size() == 3, "R7 nothing consumed", mq[2].size(), 3);

        // R8 close after data, before draining notifications
        cls_valid = 1; cls_sess = 16'd2;
        while (!cls_ready) @(negedge clk);
        @(negedge clk); cls_valid = 0;
        expect_ntf(2, 3, 32'h0B00_0002, 16'd55, 0, "R9 data before close");
        expect_ntf(2, 0, 32'h0B00_0002, 16'd55, 1, "R8 close notification");
        do_read(2, 3, "R10 data still readable");

        repeat (3) @(negedge clk);
        check(!ntf_valid && !meta_valid && !pl_valid, "R9 queue drained", {ntf_valid, meta_valid, pl_valid}, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule